// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Unit

This block keeps the interrupt-status, controller-status, command and two system-configuration registers of a flash controller. It also decides whether a command written by the host may start. The host reaches it through a simple 16-bit register write port and a combinational read port. The command engine reports each finished load, program or erase through an event strobe, together with an optional failure flag. From these registers the block drives an interrupt line and a ready line.

The interrupt register has a master bit. The engine's completion events set it, and the host clears it by writing a mask that is ANDed into the register. While the master bit is set, command writes are dropped, so the host must acknowledge the previous result before it can issue the next command. Recognised commands are handed to the engine as a one-cycle start pulse. Two reset command codes instead reinitialise the registers of this block. Any other code is flagged as a command error.

Top module: `flash_intc_unit`

## Requirements
- R1: After the asynchronous reset, the registers read as follows: configuration 1 = 0x40C0, configuration 2 = 0x0000, controller status = 0x0000, interrupt status = 0x8080, command = 0x0000. In this state the interrupt output is 1, the ready output is 1 and the start pulse is 0.
- R2: A completion event sets its done bit and master bit 15 of the interrupt status on the clock edge that samples it. The done bits are load = bit 7, program = bit 6 and erase = bit 5. Several events in one cycle all take effect.
- R3: If the failure flag is high with a completion event, that event sets command-error bit 10 of the controller status and also its own error bit: load = bit 13, program = bit 12, erase = bit 11.
- R4: A write to address 0xF241 ANDs the data into the interrupt status. If bit 15 is 0 afterwards, status bits 10 to 13 are cleared; if bit 15 stays 1, those bits are kept.
- R5: The interrupt output always equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6.
- R6: Writes to 0xF221 and 0xF222 load configuration 1 and 2. Configuration 1 reads back ANDed with 0xFFE0, and the ready output follows configuration-1 bit 7.
- R7: A write to the command address 0xF220 has no effect while interrupt-status bit 15 is 1. The command register, the start pulse and all other registers stay unchanged.
- R8: An accepted write of a recognised code stores the code in the command register, which reads at 0xF220 and drives the command output. The start pulse is high for exactly one cycle after that write. The recognised codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30 and 0x65.
- R9: An accepted write of any other code, apart from the reset codes, stores the code and sets status bit 10 and interrupt bit 15, without a start pulse.
- R10: An accepted write of 0xF0 or 0xF3 performs a warm reset. The registers take the values of R1, except that interrupt status becomes 0x8010 and no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 16 | Register read address |
| rd_data | output | 16 | Combinational read data, 0 for unmapped addresses |
| ev_load | input | 1 | Engine finished a load |
| ev_prog | input | 1 | Engine finished a program |
| ev_erase | input | 1 | Engine finished an erase |
| ev_fail | input | 1 | The events of this cycle failed |
| cmd_start | output | 1 | One-cycle start pulse for the engine |
| cmd_code | output | 16 | Currently held command code |
| irq | output | 1 | Interrupt line, polarity set by configuration 1 |
| rdy | output | 1 | Ready line |

## Verification
Every register write and every completion event takes effect on the clock edge that samples it. The read data, the interrupt line and the ready line are combinational from the registers, so they show the result during the cycle that follows that edge. The start pulse appears in that same following cycle and drops one cycle later. The bench drives its inputs after a falling edge, advances its reference model at the rising edge, and compares every output, including all five readable registers, at the next falling edge. That is exactly one edge after each stimulus, and it catches both early and late changes.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int REG_W = 16;

  localparam logic [15:0] ADDR_CMD  = 16'hF220;
  localparam logic [15:0] ADDR_CFG1 = 16'hF221;
  localparam logic [15:0] ADDR_CFG2 = 16'hF222;
  localparam logic [15:0] ADDR_STAT = 16'hF240;
  localparam logic [15:0] ADDR_INT  = 16'hF241;

  localparam int INT_MASTER = 15;
  localparam int INT_LOAD   = 7;
  localparam int INT_PROG   = 6;
  localparam int INT_ERASE  = 5;
  localparam int INT_RST    = 4;

  localparam int ST_CMD   = 10;
  localparam int ST_ERASE = 11;
  localparam int ST_PROG  = 12;
  localparam int ST_LOAD  = 13;

  localparam int CFG1_POL = 6;
  localparam int CFG1_RDY = 7;

  localparam logic [REG_W-1:0] CFG1_INIT   = 16'h40C0;
  localparam logic [REG_W-1:0] CFG1_RDMASK = 16'hFFE0;
  localparam logic [REG_W-1:0] INT_COLD    = 16'h8080;
  localparam logic [REG_W-1:0] INT_WARM    = 16'h8010;

  typedef enum logic [1:0] {CK_UNKNOWN, CK_ENGINE, CK_RESET} cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [REG_W-1:0] c);
    case (c)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065: classify = CK_ENGINE;
      16'h00F0, 16'h00F3:                               classify = CK_RESET;
      default:                                          classify = CK_UNKNOWN;
    endcase
  endfunction
endpackage

// File: rtl/fic_cmd_gate.sv
module fic_cmd_gate
  import fic_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  input  logic          master,
  output logic [DW-1:0] cmd_q,
  output logic          start_q,
  output logic          bad,
  output logic          warm
);
  cmd_kind_e    kind;
  logic         accept;
  logic [DW-1:0] cmd_n;
  logic         start_n;

  always_comb begin
    kind    = classify(wdata);
    accept  = wr_cmd && !master;
    bad     = accept && (kind == CK_UNKNOWN);
    warm    = accept && (kind == CK_RESET);
    start_n = accept && (kind == CK_ENGINE);
    cmd_n   = cmd_q;
    if (warm)        cmd_n = '0;
    else if (accept) cmd_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_n;
      start_q <= start_n;
    end
  end

  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && master) |=> (!start_q && $stable(cmd_q)));

  p_start_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q || $past(start_n));
endmodule

// File: rtl/fic_cfg_regs.sv
module fic_cfg_regs
  import fic_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cfg1,
  input  logic          wr_cfg2,
  input  logic [DW-1:0] wdata,
  input  logic          warm,
  output logic [DW-1:0] cfg1_q,
  output logic [DW-1:0] cfg2_q
);
  logic [DW-1:0] cfg1_n, cfg2_n;

  always_comb begin
    cfg1_n = cfg1_q;
    cfg2_n = cfg2_q;
    if (warm) begin
      cfg1_n = CFG1_INIT;
      cfg2_n = '0;
    end else begin
      if (wr_cfg1) cfg1_n = wdata;
      if (wr_cfg2) cfg2_n = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= CFG1_INIT;
      cfg2_q <= '0;
    end else begin
      cfg1_q <= cfg1_n;
      cfg2_q <= cfg2_n;
    end
  end

  p_cfg1_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg1 && !warm) |=> (cfg1_q[CFG1_RDY] == $past(wdata[CFG1_RDY])));
endmodule

// File: rtl/fic_int_regs.sv
module fic_int_regs
  import fic_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_int,
  input  logic [DW-1:0] wdata,
  input  logic          warm,
  input  logic          bad,
  input  logic          ev_load,
  input  logic          ev_prog,
  input  logic          ev_erase,
  input  logic          ev_fail,
  output logic [DW-1:0] int_q,
  output logic [DW-1:0] stat_q
);
  localparam int NEV = 3;
  logic [NEV-1:0] ev_vec;
  logic [DW-1:0]  int_n, stat_n, int_set, stat_set;
  logic           ev_any;

  localparam int DONE_BIT [NEV] = '{INT_LOAD, INT_PROG, INT_ERASE};
  localparam int ERR_BIT  [NEV] = '{ST_LOAD, ST_PROG, ST_ERASE};

  assign ev_vec = {ev_erase, ev_prog, ev_load};
  assign ev_any = |ev_vec;

  always_comb begin
    int_set  = '0;
    stat_set = '0;
    for (int i = 0; i < NEV; i++) begin
      if (ev_vec[i]) begin
        int_set[DONE_BIT[i]]   = 1'b1;
        int_set[INT_MASTER]    = 1'b1;
        if (ev_fail) begin
          stat_set[ERR_BIT[i]] = 1'b1;
          stat_set[ST_CMD]     = 1'b1;
        end
      end
    end
  end

  always_comb begin
    int_n  = int_q;
    stat_n = stat_q;
    if (warm) begin
      int_n  = INT_WARM;
      stat_n = '0;
    end else if (bad) begin
      int_n[INT_MASTER] = 1'b1;
      stat_n[ST_CMD]    = 1'b1;
    end else if (wr_int) begin
      int_n = int_q & wdata;
      if (!int_n[INT_MASTER]) stat_n[ST_LOAD:ST_CMD] = '0;
    end
    int_n  = int_n | int_set;
    stat_n = stat_n | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else begin
      int_q  <= int_n;
      stat_q <= stat_n;
    end
  end

  p_done_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> int_q[INT_MASTER]);

  p_fail_cmd_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_any && ev_fail) |=> stat_q[ST_CMD]);

  p_err_wipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && !wdata[INT_MASTER] && !ev_any) |=>
      (!int_q[INT_MASTER] && stat_q[ST_LOAD:ST_CMD] == '0));

  p_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (stat_q[ST_CMD] && int_q[INT_MASTER]));

  p_warm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !ev_any) |=> (int_q == INT_WARM && stat_q == '0));
endmodule

// File: rtl/flash_intc_unit.sv
module flash_intc_unit
  import fic_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ev_load,
  input  logic          ev_prog,
  input  logic          ev_erase,
  input  logic          ev_fail,
  output logic          cmd_start,
  output logic [DW-1:0] cmd_code,
  output logic          irq,
  output logic          rdy
);
  logic          wr_cmd, wr_cfg1, wr_cfg2, wr_int;
  logic          bad, warm;
  logic [DW-1:0] cfg1_q, cfg2_q, int_q, stat_q;

  assign wr_cmd  = wr_en && (wr_addr == AW'(ADDR_CMD));
  assign wr_cfg1 = wr_en && (wr_addr == AW'(ADDR_CFG1));
  assign wr_cfg2 = wr_en && (wr_addr == AW'(ADDR_CFG2));
  assign wr_int  = wr_en && (wr_addr == AW'(ADDR_INT));

  fic_cmd_gate #(.DW(DW)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(wr_data),
    .master(int_q[INT_MASTER]), .cmd_q(cmd_code), .start_q(cmd_start),
    .bad(bad), .warm(warm)
  );

  fic_cfg_regs #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_cfg1(wr_cfg1), .wr_cfg2(wr_cfg2),
    .wdata(wr_data), .warm(warm), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q)
  );

  fic_int_regs #(.DW(DW)) u_int (
    .clk(clk), .rst_n(rst_n), .wr_int(wr_int), .wdata(wr_data),
    .warm(warm), .bad(bad), .ev_load(ev_load), .ev_prog(ev_prog),
    .ev_erase(ev_erase), .ev_fail(ev_fail), .int_q(int_q), .stat_q(stat_q)
  );

  assign irq = int_q[INT_MASTER] ^ ~cfg1_q[CFG1_POL];
  assign rdy = cfg1_q[CFG1_RDY];

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADDR_CMD))       rd_data = cmd_code;
    else if (rd_addr == AW'(ADDR_CFG1)) rd_data = cfg1_q & CFG1_RDMASK;
    else if (rd_addr == AW'(ADDR_CFG2)) rd_data = cfg2_q;
    else if (rd_addr == AW'(ADDR_STAT)) rd_data = stat_q;
    else if (rd_addr == AW'(ADDR_INT))  rd_data = int_q;
  end

  p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cfg1_q) && $rose(int_q[INT_MASTER])) |-> (irq == cfg1_q[CFG1_POL]));
endmodule

// File: tb/tb_flash_intc_unit.sv
module tb_flash_intc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        ev_load = 1'b0, ev_prog = 1'b0, ev_erase = 1'b0, ev_fail = 1'b0;
  logic        cmd_start;
  logic [15:0] cmd_code;
  logic        irq, rdy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_cfg1, m_cfg2, m_st, m_int, m_cmd;
  logic        m_start;

  always #10 clk = ~clk;

  flash_intc_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_load(ev_load), .ev_prog(ev_prog), .ev_erase(ev_erase),
    .ev_fail(ev_fail), .cmd_start(cmd_start), .cmd_code(cmd_code),
    .irq(irq), .rdy(rdy)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic model_reset(input bit cold);
    m_cfg1 = 16'h40C0; m_cfg2 = 16'h0000; m_st = 16'h0000; m_cmd = 16'h0000;
    m_int = cold ? 16'h8080 : 16'h8010;
  endtask

  function automatic bit known(input logic [15:0] c);
    case (c)
      16'h00, 16'h13, 16'h80, 16'h1A, 16'h1B, 16'h23, 16'h27, 16'h2A,
      16'h2C, 16'h71, 16'h94, 16'h95, 16'hB0, 16'h30, 16'h65: known = 1;
      default: known = 0;
    endcase
  endfunction

  task automatic model_step();
    m_start = 0;
    if (wr_en) begin
      case (wr_addr)
        16'hF220: if (!m_int[15]) begin
          if (wr_data == 16'hF0 || wr_data == 16'hF3) model_reset(0);
          else begin
            m_cmd = wr_data;
            if (known(wr_data)) m_start = 1;
            else begin m_st = m_st | 16'h0400; m_int = m_int | 16'h8000; end
          end
        end
        16'hF221: m_cfg1 = wr_data;
        16'hF222: m_cfg2 = wr_data;
        16'hF241: begin
          m_int = m_int & wr_data;
          if (!m_int[15]) m_st = m_st & ~16'h3C00;
        end
        default: ;
      endcase
    end
    if (ev_load)  begin m_int = m_int | 16'h8080; if (ev_fail) m_st = m_st | 16'h2400; end
    if (ev_prog)  begin m_int = m_int | 16'h8040; if (ev_fail) m_st = m_st | 16'h1400; end
    if (ev_erase) begin m_int = m_int | 16'h8020; if (ev_fail) m_st = m_st | 16'h0C00; end
  endtask

  task automatic compare_all();
    logic [15:0] v;
    chk("R5 irq", {15'd0, irq}, {15'd0, m_int[15] ^ ~m_cfg1[6]});
    chk("R6 rdy", {15'd0, rdy}, {15'd0, m_cfg1[7]});
    chk("R8 start", {15'd0, cmd_start}, {15'd0, m_start});
    chk("R8 code", cmd_code, m_cmd);
    rd(16'hF241, v); chk("R2 intstatus", v, m_int);
    rd(16'hF240, v); chk("R3 status", v, m_st);
    rd(16'hF221, v); chk("R6 cfg1", v, m_cfg1 & 16'hFFE0);
    rd(16'hF222, v); chk("R6 cfg2", v, m_cfg2);
    rd(16'hF220, v); chk("R8 cmdreg", v, m_cmd);
  endtask

  task automatic step(input bit we, input logic [15:0] a, input logic [15:0] d,
                      input bit l, input bit p, input bit e, input bit f);
    wr_en = we; wr_addr = a; wr_data = d;
    ev_load = l; ev_prog = p; ev_erase = e; ev_fail = f;
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 0; ev_load = 0; ev_prog = 0; ev_erase = 0; ev_fail = 0;
    compare_all();
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    step(1, a, d, 0, 0, 0, 0);
  endtask

  task automatic idle();
    step(0, 16'h0, 16'h0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    model_reset(1); m_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 cold reset state
    rd(16'hF221, v); chk("R1 cfg1", v, 16'h40C0);
    rd(16'hF222, v); chk("R1 cfg2", v, 16'h0000);
    rd(16'hF240, v); chk("R1 status", v, 16'h0000);
    rd(16'hF241, v); chk("R1 intstatus", v, 16'h8080);
    chk("R1 irq/rdy/start", {13'd0, irq, rdy, cmd_start}, 16'h0006);

    // R7 command refused while master set
    wr(16'hF220, 16'h0094);
    rd(16'hF220, v); chk("R7 cmd unchanged", v, 16'h0000);
    chk("R7 no start", {15'd0, cmd_start}, 16'h0);
    wr(16'hF241, 16'h0000);
    chk("R5 irq low", {15'd0, irq}, 16'h0);
    // R8 accepted erase command
    wr(16'hF220, 16'h0094);
    chk("R8 start pulse", {15'd0, cmd_start}, 16'h1);
    idle();
    chk("R8 pulse one cycle", {15'd0, cmd_start}, 16'h0);
    // R2/R3 failed erase
    step(0, 0, 0, 0, 0, 1, 1);
    rd(16'hF240, v); chk("R3 erase err", v, 16'h0C00);
    rd(16'hF241, v); chk("R2 erase done", v, 16'h8020);
    wr(16'hF220, 16'h0000);
    rd(16'hF220, v); chk("R7 blocked again", v, 16'h0094);
    // R4 clear master wipes errors
    wr(16'hF241, 16'h7FFF);
    rd(16'hF240, v); chk("R4 errors wiped", v, 16'h0000);
    rd(16'hF241, v); chk("R4 and result", v, 16'h0020);
    // R9 unknown command
    wr(16'hF220, 16'h0055);
    rd(16'hF240, v); chk("R9 cmd err", v, 16'h0400);
    rd(16'hF241, v); chk("R9 master", v, 16'h8020);
    // R4 master kept -> errors kept
    wr(16'hF241, 16'h8000);
    rd(16'hF240, v); chk("R4 errors kept", v, 16'h0400);
    wr(16'hF241, 16'h0000);
    // R6 config
    wr(16'hF221, 16'h00BF);
    rd(16'hF221, v); chk("R6 cfg1 mask", v, 16'h00A0);
    chk("R5 irq inverted pol", {14'd0, irq, rdy}, 16'h0003);
    wr(16'hF221, 16'h0040);
    chk("R6 rdy low", {14'd0, irq, rdy}, 16'h0000);
    wr(16'hF222, 16'h1234);
    // R2 simultaneous events with AND-write in same cycle
    step(1, 16'hF241, 16'h0000, 1, 1, 0, 0);
    rd(16'hF241, v); chk("R2 two events", v, 16'h80C0);
    wr(16'hF241, 16'h0000);
    // R10 warm reset
    wr(16'hF220, 16'h00F3);
    rd(16'hF241, v); chk("R10 intstatus", v, 16'h8010);
    rd(16'hF221, v); chk("R10 cfg1", v, 16'h40C0);
    rd(16'hF222, v); chk("R10 cfg2", v, 16'h0000);
    rd(16'hF220, v); chk("R10 cmd", v, 16'h0000);
    wr(16'hF241, 16'h0000);
    wr(16'hF220, 16'h00F0);
    rd(16'hF241, v); chk("R10 F0 warm", v, 16'h8010);

    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a, d;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 16'hF220;
        1: a = 16'hF221;
        2: a = 16'hF222;
        3: a = 16'hF241;
        4: a = 16'hF240;
        default: a = 16'h1000;
      endcase
      d = $urandom;
      if (a == 16'hF220) begin
        case ($urandom_range(0, 4))
          0: d = 16'h00F0;
          1: d = 16'h0055;
          2: d = 16'h0013;
          3: d = 16'h0065;
          default: d = 16'h0080;
        endcase
      end
      if (a == 16'hF241 && $urandom_range(0, 1) == 0) d = 16'h0000;
      step($urandom_range(0, 2) != 0, a, d,
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule